// File: doc/BRIEF.md
# Flash Ready/Busy Status and Interrupt Unit

This block keeps the status flags and interrupt-enable bits for a NAND flash controller. It brings up to four external ready/busy pins into the clock domain through two-flop synchronisers. It watches one of them, chosen by a select input, for a change from busy (0) to ready (1). It also latches command-done and DMA-done pulses from the controller's sequencer and DMA engine. It does not contain either of those.

Software reaches the block through a one-bit-address register port. Address 0 is the status register and address 1 is the interrupt-enable register. Each event sets a sticky flag, and writing 1 to a flag's bit clears it. The single level interrupt output is active while any flag is set together with its enable bit. The status register also shows whether the command queue is busy, and it shows the synchronised level of every ready/busy pin.

Top module: `flash_rb_intr`

## Requirements
- R1: While reset is held and just after it is released, status bits 2:0 read 0, the enable register reads 0 and `irq` is 0. The synchronised levels reset to 1 (ready), so pins that are held high through reset set no flag.
- R2: A 0-to-1 change on the pin picked by `rbSel` sets status bit 0 on the third rising clock edge after the pin changes. A 1-to-0 change on that pin leaves bit 0 clear.
- R3: A change in either direction on any pin not picked by `rbSel` leaves status bit 0 unchanged.
- R4: A one-cycle `cmdDone` pulse sets status bit 1 and a one-cycle `dmaDone` pulse sets status bit 2. Both flags stay set after the pulse ends.
- R5: A write to address 0 clears each of status bits 2:0 whose write-data bit is 1 and leaves each flag whose write-data bit is 0 unchanged. Writing to any other status bit has no effect.
- R6: When a set event and a write-one clear hit the same flag in the same cycle, the flag ends that cycle set.
- R7: Status bit 3 reads the current value of `cmdQueueBusy`: 1 while the command queue holds or is running a command, and 0 when it is empty.
- R8: Status bits 11:8 show the synchronised levels of pins 3:0. A pin change becomes visible on the second rising edge after it.
- R9: A write to address 1 loads write-data bits 2:0 into the enable register. Bit 0 enables busy-to-ready, bit 1 enables command done and bit 2 enables DMA done. Reading address 1 returns those three bits, and all higher bits read 0.
- R10: `irq` is 1 exactly when at least one of status bits 2:0 is set together with the enable bit of the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rbPins | input | NUM_RB | Raw ready/busy pins, 1 = ready |
| rbSel | input | SEL_W | Index of the pin that feeds the busy-to-ready detector |
| cmdDone | input | 1 | One-cycle command-complete pulse |
| dmaDone | input | 1 | One-cycle DMA-complete pulse |
| cmdQueueBusy | input | 1 | Command queue not empty or executing |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = status, 1 = interrupt enable |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data for `regAddr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker checks on every cycle that the flags are sticky and that a write-one clear works. It also checks that a pulse sets its flag even when a clear hits the same flag in that cycle, and that `irq` stays low with no enable bit or no flag set. Only the bench's scenarios can show the exact synchroniser latency, the selection of the detector's pin, and that falling edges and edges on other pins are ignored. The same holds for the queue-busy and level bits and for the full sweep of enable and flag patterns against the interrupt output.

// File: rtl/flash_rb_pkg.sv
`timescale 1ns/1ps
package flash_rb_pkg;
  localparam int FLAG_N    = 3;
  localparam int FLAG_RB   = 0;
  localparam int FLAG_CMD  = 1;
  localparam int FLAG_DMA  = 2;
  localparam int QBUSY_BIT = 3;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;

  typedef struct packed {
    logic [FLAG_N-1:0] setMask;
    logic [FLAG_N-1:0] clrMask;
    logic              enWr;
    logic [FLAG_N-1:0] enData;
  } ctlStrobe_t;
endpackage

// File: rtl/flash_rb_ctl.sv
`timescale 1ns/1ps
module flash_rb_ctl
  import flash_rb_pkg::*;
#(
  parameter int NUM_RB = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_RB-1:0] rbLevel,
  input  logic [SEL_W-1:0]  rbSel,
  input  logic              cmdDone,
  input  logic              dmaDone,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [FLAG_N-1:0] wrBits,
  output ctlStrobe_t        strobe
);
  // Per-line history so that changing rbSel never fakes an edge
  logic [NUM_RB-1:0] prevLevel;
  logic [NUM_RB-1:0] riseVec;
  logic              rbRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevLevel <= '1;
    else        prevLevel <= rbLevel;
  end

  assign riseVec = rbLevel & ~prevLevel;
  assign rbRise  = riseVec[rbSel];

  always_comb begin
    strobe                   = '0;
    strobe.setMask[FLAG_RB]  = rbRise;
    strobe.setMask[FLAG_CMD] = cmdDone;
    strobe.setMask[FLAG_DMA] = dmaDone;
    strobe.clrMask = (regWrEn && regAddr == ADDR_STATUS) ? wrBits : '0;
    strobe.enWr    = regWrEn && regAddr == ADDR_ENABLE;
    strobe.enData  = wrBits;
  end
endmodule

// File: rtl/flash_rb_dp.sv
`timescale 1ns/1ps
module flash_rb_dp
  import flash_rb_pkg::*;
#(
  parameter int NUM_RB      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_LSB   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_RB-1:0] rbPins,
  input  logic              cmdQueueBusy,
  input  logic              regAddr,
  input  ctlStrobe_t        strobe,
  output logic [NUM_RB-1:0] rbLevel,
  output logic [FLAG_N-1:0] flagQ,
  output logic [FLAG_N-1:0] enableQ,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);
  logic [NUM_RB-1:0] syncStage [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncStage[0] <= '1;
    else        syncStage[0] <= rbPins;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) syncStage[s] <= '1;
      else        syncStage[s] <= syncStage[s-1];
    end
  end

  assign rbLevel = syncStage[SYNC_STAGES-1];

  // Set term is applied after the clear term: a same-cycle event wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagQ   <= '0;
      enableQ <= '0;
    end else begin
      flagQ <= (flagQ & ~strobe.clrMask) | strobe.setMask;
      if (strobe.enWr) enableQ <= strobe.enData;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_STATUS) begin
      regRdData[FLAG_N-1:0]          = flagQ;
      regRdData[QBUSY_BIT]           = cmdQueueBusy;
      regRdData[LEVEL_LSB +: NUM_RB] = rbLevel;
    end else begin
      regRdData[FLAG_N-1:0] = enableQ;
    end
  end

  assign irq = |(flagQ & enableQ);
endmodule

// File: rtl/flash_rb_intr.sv
`timescale 1ns/1ps
module flash_rb_intr
  import flash_rb_pkg::*;
#(
  parameter int NUM_RB      = 4,
  parameter int SEL_W       = (NUM_RB > 1) ? $clog2(NUM_RB) : 1,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_LSB   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_RB-1:0] rbPins,
  input  logic [SEL_W-1:0]  rbSel,
  input  logic              cmdDone,
  input  logic              dmaDone,
  input  logic              cmdQueueBusy,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);
  ctlStrobe_t        strobe;
  logic [NUM_RB-1:0] rbLevel;
  logic [FLAG_N-1:0] flagQ;
  logic [FLAG_N-1:0] enableQ;
  logic              unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:FLAG_N];

  flash_rb_ctl #(.NUM_RB(NUM_RB), .SEL_W(SEL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .rbLevel(rbLevel), .rbSel(rbSel),
    .cmdDone(cmdDone), .dmaDone(dmaDone), .regWrEn(regWrEn),
    .regAddr(regAddr), .wrBits(regWrData[FLAG_N-1:0]), .strobe(strobe)
  );

  flash_rb_dp #(
    .NUM_RB(NUM_RB), .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES), .LEVEL_LSB(LEVEL_LSB)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .rbPins(rbPins), .cmdQueueBusy(cmdQueueBusy),
    .regAddr(regAddr), .strobe(strobe), .rbLevel(rbLevel), .flagQ(flagQ),
    .enableQ(enableQ), .regRdData(regRdData), .irq(irq)
  );
endmodule

// File: rtl/flash_rb_intr_chk.sv
`timescale 1ns/1ps
module flash_rb_intr_chk
  import flash_rb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmdDone,
  input logic              dmaDone,
  input logic              regWrEn,
  input logic              regAddr,
  input logic [FLAG_N-1:0] wrBits,
  input logic [FLAG_N-1:0] flagQ,
  input logic [FLAG_N-1:0] enableQ,
  input logic              irq
);
  logic [FLAG_N-1:0] clrReq;
  assign clrReq = (regWrEn && regAddr == ADDR_STATUS) ? wrBits : '0;

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flagQ != 0 |=> ((($past(flagQ) & ~$past(clrReq)) & ~flagQ) == 0)); // R4
  AST_DMA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    dmaDone |=> flagQ[FLAG_DMA]); // R4
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clrReq[FLAG_CMD] && !cmdDone) |=> !flagQ[FLAG_CMD]); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdDone && clrReq[FLAG_CMD]) |=> flagQ[FLAG_CMD]); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enableQ == 0) |-> !irq); // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flagQ == 0) |-> !irq); // R10
endmodule

bind flash_rb_intr flash_rb_intr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmdDone(cmdDone), .dmaDone(dmaDone),
  .regWrEn(regWrEn), .regAddr(regAddr),
  .wrBits(regWrData[flash_rb_pkg::FLAG_N-1:0]),
  .flagQ(flagQ), .enableQ(enableQ), .irq(irq)
);

// File: tb/flash_rb_intr_tb.sv
`timescale 1ns/1ps
module flash_rb_intr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rbPins = 4'hF;
  logic [1:0]  rbSel = 2'd0;
  logic        cmdDone = 1'b0;
  logic        dmaDone = 1'b0;
  logic        cmdQueueBusy = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  flash_rb_intr u_dut (
    .clk(clk), .rst_n(rst_n), .rbPins(rbPins), .rbSel(rbSel),
    .cmdDone(cmdDone), .dmaDone(dmaDone), .cmdQueueBusy(cmdQueueBusy),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readReg(input logic a, output logic [31:0] v);
    regAddr = a;
    #0.5;
    v = regRdData;
  endtask

  task automatic writeReg(input logic a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step(1);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulseCmd();
    cmdDone = 1'b1; step(1); cmdDone = 1'b0;
  endtask

  task automatic pulseDma();
    dmaDone = 1'b1; step(1); dmaDone = 1'b0;
  endtask

  // Busy then ready on line 0 while it is the selected line
  task automatic pulseRb0();
    rbSel = 2'd0;
    rbPins[0] = 1'b0; step(4);
    rbPins[0] = 1'b1; step(4);
  endtask

  initial begin
    #750000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    step(1);
    readReg(1'b0, v); check("R1 status in reset", v & 32'h7, 32'h0);
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    step(2);
    rst_n = 1'b1;
    step(4);
    readReg(1'b0, v); check("R1 status after reset", v & 32'h7, 32'h0);
    check("R8 levels after reset", (v >> 8) & 32'hF, 32'hF);
    readReg(1'b1, v); check("R1 enable after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2 / R3 / R8: every select value against every line
    for (int sel = 0; sel < 4; sel++) begin
      for (int ln = 0; ln < 4; ln++) begin
        rbSel = 2'(sel);
        writeReg(1'b0, 32'h7);
        rbPins[ln] = 1'b0;
        step(4);
        readReg(1'b0, v);
        check("R2 R3 falling edge sets nothing", v & 32'h1, 32'h0);
        check("R8 busy level shown", (v >> 8) & 32'hF, 32'hF & ~(32'h1 << ln));
        rbPins[ln] = 1'b1;
        step(1);
        readReg(1'b0, v);
        check("R8 level one edge later still old", (v >> 8) & 32'hF, 32'hF & ~(32'h1 << ln));
        step(1);
        readReg(1'b0, v);
        check("R8 level two edges later new", (v >> 8) & 32'hF, 32'hF);
        check("R2 flag not yet set", v & 32'h1, 32'h0);
        step(1);
        readReg(1'b0, v);
        check(ln == sel ? "R2 selected rise sets flag" : "R3 other line ignored",
              v & 32'h1, (ln == sel) ? 32'h1 : 32'h0);
      end
    end

    // R4 / R5 / R9 / R10: sweep of enables and flag patterns
    for (int en = 0; en < 8; en++) begin
      for (int f = 0; f < 8; f++) begin
        writeReg(1'b0, 32'hFFFF_FFFF);
        writeReg(1'b1, 32'hFFFF_FFF8 | 32'(en));
        if (f[0]) pulseRb0();
        if (f[1]) pulseCmd();
        if (f[2]) pulseDma();
        step(2);
        readReg(1'b0, v);
        check("R4 flags sticky", v & 32'h7, 32'(f));
        readReg(1'b1, v);
        check("R9 enable readback", v, 32'(en));
        check("R10 irq", {31'b0, irq}, ((en & f) != 0) ? 32'h1 : 32'h0);
      end
    end

    // R5: partial clear, zero bits leave flags alone
    writeReg(1'b1, 32'h0);
    pulseRb0(); pulseCmd(); pulseDma();
    writeReg(1'b0, 32'h0);
    readReg(1'b0, v); check("R5 write zero keeps flags", v & 32'h7, 32'h7);
    writeReg(1'b0, 32'h2);
    readReg(1'b0, v); check("R5 clear bit1 only", v & 32'h7, 32'h5);
    writeReg(1'b0, 32'h5);
    readReg(1'b0, v); check("R5 clear remaining", v & 32'h7, 32'h0);

    // R6: set and clear in the same cycle
    regAddr = 1'b0; regWrData = 32'h6; regWrEn = 1'b1; cmdDone = 1'b1; dmaDone = 1'b1;
    step(1);
    regWrEn = 1'b0; cmdDone = 1'b0; dmaDone = 1'b0; regWrData = '0;
    readReg(1'b0, v); check("R6 set wins over clear", v & 32'h7, 32'h6);

    // R7: queue-busy bit follows its input
    cmdQueueBusy = 1'b1; readReg(1'b0, v); check("R7 queue busy", (v >> 3) & 32'h1, 32'h1);
    cmdQueueBusy = 1'b0; readReg(1'b0, v); check("R7 queue empty", (v >> 3) & 32'h1, 32'h0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule